// File: doc/BRIEF.md
# Differential Line Writer with Per-Word Inversion

This block sits between a cache-line requester and a resistive nonvolatile memory array whose cells are slow and costly to program. Every line write becomes a read-compare-write: the block first fetches the stored image of the line. For each 32-bit word it then picks whichever of the plain or complemented form of the new data changes fewer stored cells. It programs only the slices of the stored row that actually change, and only the changed bits within them.

Each stored word carries one extra marker bit that tells whether the word is held complemented. Line reads fetch the stored row and undo the complement per word, so the encoding is invisible to the requester. After each line write the block reports how many slice write cycles it issued and how many cells it changed. Only one line operation is handled at a time.

Top module: `fnw_line_writer`

## Requirements
- R1: After reset, req_ready is 1 and arr_valid and rsp_valid are 0.
- R2: A line write starts with a whole-row array read (arr_we=0) of the requested address, and no slice write for that operation is issued before that read is accepted.
- R3: The stored word layout is a marker bit at bit 32 above 32 data bits, and word w occupies row bits [33*w+32 : 33*w]. For each word the cost of a form is the number of its 33 stored bits that differ from the old stored word. The complemented form (marker 1) is stored only when its cost is strictly lower than the plain form's cost (marker 0).
- R4: After a line write the stored row equals the chosen encoding of every word. The write mask of each slice is exactly the set of bits that differ from the old row.
- R5: The row is written in 8 slices of 66 bits (two words each; slice s holds words 2s and 2s+1). A slice with no changed bit gets no array write, and every issued write has a non-zero mask.
- R6: On a write response, rsp_wr_cycles equals the number of slice writes issued and rsp_flips equals the total number of stored cells that changed.
- R7: A line read returns each word's stored data bits XORed with its replicated marker bit.
- R8: Once a request is accepted, req_ready stays 0 until the one-cycle rsp_valid pulse; only one operation is in flight.
- R9: While arr_valid is 1 and arr_ready is 0, the array request (address, slice, direction, data) holds steady.
- R10: Rewriting a line with the data it already holds issues no slice write and reports zero flipped cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_we | input | 1 | 1 = line write, 0 = line read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | LINE_W | Line data for writes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LINE_W | Decoded line for reads |
| rsp_wr_cycles | output | clog2(NS+1) | Slice writes issued by the last write |
| rsp_flips | output | clog2(ROW_W+1) | Stored cells changed by the last write |
| arr_valid | output | 1 | Array request valid |
| arr_ready | input | 1 | Array accepts the request |
| arr_we | output | 1 | 1 = masked slice write, 0 = row read |
| arr_addr | output | ADDR_W | Array row address |
| arr_slice | output | clog2(NS) | Slice index for writes |
| arr_wdata | output | SW | Slice write data |
| arr_wmask | output | SW | Slice bit write enables |
| arr_rvalid | input | 1 | Row read data valid |
| arr_rdata | input | ROW_W | Stored row including marker bits |

## Verification
Every cycle the assertions check the handshake rules: a request stays stable while the array stalls, the requester is held off after acceptance, the completion pulse lasts one cycle, no write carries an empty mask, and a write response with no cycles reports no flips. The choice of encoding per word, the exact stored image, the number of skipped slices, the flip totals and the decoding of complemented words depend on the data. Only the bench's scenarios can show them, by comparing an array model against an independently computed encoding for all-zero, all-one, single-word, rewrite and random lines.

// File: rtl/fnw_pkg.sv
package fnw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR,
        ST_RESP
    } fnw_state_e;
endpackage

// File: rtl/fnw_word_enc.sv
module fnw_word_enc #(
    parameter int WORD_W = 32,
    localparam int CW   = WORD_W + 1,
    localparam int WF_W = $clog2(CW + 1)
) (
    input  logic [CW-1:0]     old_word,
    input  logic [WORD_W-1:0] new_data,
    output logic [CW-1:0]     enc_word,
    output logic [WF_W-1:0]   flips
);
    logic [WORD_W-1:0] diff_plain;
    logic [WF_W-1:0]   cost_plain;
    logic [WF_W-1:0]   cost_inv;
    logic              use_inv;

    always_comb begin
        diff_plain = old_word[WORD_W-1:0] ^ new_data;
        cost_plain = WF_W'(old_word[WORD_W]);
        for (int i = 0; i < WORD_W; i++) begin
            cost_plain = cost_plain + WF_W'(diff_plain[i]);
        end
        // every stored bit differs from exactly one of the two forms
        cost_inv = WF_W'(CW) - cost_plain;
        use_inv  = cost_inv < cost_plain;
        enc_word = use_inv ? {1'b1, ~new_data} : {1'b0, new_data};
        flips    = use_inv ? cost_inv : cost_plain;
    end
endmodule

// File: rtl/fnw_word_dec.sv
module fnw_word_dec #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W:0]   stored,
    output logic [WORD_W-1:0] data
);
    assign data = stored[WORD_W-1:0] ^ {WORD_W{stored[WORD_W]}};
endmodule

// File: rtl/fnw_line_writer.sv
module fnw_line_writer #(
    parameter int LINE_W  = 512,
    parameter int WORD_W  = 32,
    parameter int SLICE_W = 64,
    parameter int ADDR_W  = 8,
    localparam int NW    = LINE_W / WORD_W,
    localparam int WPS   = SLICE_W / WORD_W,
    localparam int NS    = NW / WPS,
    localparam int CW    = WORD_W + 1,
    localparam int ROW_W = NW * CW,
    localparam int SW    = WPS * CW,
    localparam int SI_W  = (NS > 1) ? $clog2(NS) : 1,
    localparam int CYC_W = $clog2(NS + 1),
    localparam int FL_W  = $clog2(ROW_W + 1),
    localparam int WF_W  = $clog2(CW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_rdata,
    output logic [CYC_W-1:0]  rsp_wr_cycles,
    output logic [FL_W-1:0]   rsp_flips,
    output logic              arr_valid,
    input  logic              arr_ready,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [SI_W-1:0]   arr_slice,
    output logic [SW-1:0]     arr_wdata,
    output logic [SW-1:0]     arr_wmask,
    input  logic              arr_rvalid,
    input  logic [ROW_W-1:0]  arr_rdata
);
    import fnw_pkg::*;

    typedef struct packed {
        fnw_state_e        st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] wdata;
        logic [ROW_W-1:0]  enc;
        logic [ROW_W-1:0]  diff;
        logic [SI_W-1:0]   slice;
        logic [CYC_W-1:0]  cycles;
        logic [FL_W-1:0]   flips;
        logic [LINE_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic [ROW_W-1:0]  enc_line;
    logic [LINE_W-1:0] dec_line;
    logic [WF_W-1:0]   wflips [NW];
    logic [FL_W-1:0]   flip_total;
    logic [SW-1:0]     slice_diff;
    logic              last_slice;

    for (genvar w = 0; w < NW; w++) begin : g_word
        fnw_word_enc #(.WORD_W(WORD_W)) u_enc (
            .old_word (arr_rdata[w*CW +: CW]),
            .new_data (q.wdata[w*WORD_W +: WORD_W]),
            .enc_word (enc_line[w*CW +: CW]),
            .flips    (wflips[w])
        );
        fnw_word_dec #(.WORD_W(WORD_W)) u_dec (
            .stored (arr_rdata[w*CW +: CW]),
            .data   (dec_line[w*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        flip_total = '0;
        for (int w = 0; w < NW; w++) begin
            flip_total = flip_total + FL_W'(wflips[w]);
        end
    end

    assign slice_diff = q.diff[int'(q.slice)*SW +: SW];
    assign last_slice = (q.slice == SI_W'(NS - 1));

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_RD_REQ;
                    d.we     = req_we;
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    d.cycles = '0;
                    d.flips  = '0;
                    d.slice  = '0;
                end
            end
            ST_RD_REQ: begin
                if (arr_ready) d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (arr_rvalid) begin
                    if (q.we) begin
                        d.enc   = enc_line;
                        d.diff  = enc_line ^ arr_rdata;
                        d.flips = flip_total;
                        d.slice = '0;
                        d.st    = ST_WR;
                    end else begin
                        d.rdata = dec_line;
                        d.st    = ST_RESP;
                    end
                end
            end
            ST_WR: begin
                if (slice_diff == '0 || arr_ready) begin
                    if (slice_diff != '0) d.cycles = q.cycles + CYC_W'(1);
                    if (last_slice) d.st = ST_RESP;
                    else            d.slice = q.slice + SI_W'(1);
                end
            end
            ST_RESP: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign arr_valid     = (q.st == ST_RD_REQ) || (q.st == ST_WR && slice_diff != '0);
    assign arr_we        = (q.st == ST_WR);
    assign arr_addr      = q.addr;
    assign arr_slice     = q.slice;
    assign arr_wdata     = q.enc[int'(q.slice)*SW +: SW];
    assign arr_wmask     = slice_diff;
    assign rsp_valid     = (q.st == ST_RESP);
    assign rsp_rdata     = q.rdata;
    assign rsp_wr_cycles = q.cycles;
    assign rsp_flips     = q.flips;

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_we) && $stable(arr_addr)
                                       && $stable(arr_slice) && $stable(arr_wdata)));

    assert_no_empty_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_we) |-> (arr_wmask != '0));

    assert_no_cycles_no_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr_cycles == '0) |-> (rsp_flips == '0));
endmodule

// File: tb/fnw_line_writer_tb.sv
module fnw_line_writer_tb;
    localparam int LINE_W = 512;
    localparam int WORD_W = 32;
    localparam int SLICE_W = 64;
    localparam int ADDR_W = 2;
    localparam int NW = LINE_W / WORD_W;
    localparam int WPS = SLICE_W / WORD_W;
    localparam int NS = NW / WPS;
    localparam int CW = WORD_W + 1;
    localparam int ROW_W = NW * CW;
    localparam int SW = WPS * CW;
    localparam int SI_W = $clog2(NS);
    localparam int CYC_W = $clog2(NS + 1);
    localparam int FL_W = $clog2(ROW_W + 1);
    localparam int NA = 1 << ADDR_W;

    logic clk = 0;
    logic rst_n = 0;
    always #4 clk = ~clk;

    logic              req_valid = 0, req_we = 0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LINE_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [LINE_W-1:0] rsp_rdata;
    logic [CYC_W-1:0]  rsp_wr_cycles;
    logic [FL_W-1:0]   rsp_flips;
    logic              arr_valid, arr_we;
    logic              arr_ready;
    logic [ADDR_W-1:0] arr_addr;
    logic [SI_W-1:0]   arr_slice;
    logic [SW-1:0]     arr_wdata, arr_wmask;
    logic              arr_rvalid;
    logic [ROW_W-1:0]  arr_rdata;

    fnw_line_writer #(.LINE_W(LINE_W), .WORD_W(WORD_W), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_wr_cycles(rsp_wr_cycles), .rsp_flips(rsp_flips),
        .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_slice(arr_slice),
        .arr_wdata(arr_wdata), .arr_wmask(arr_wmask),
        .arr_rvalid(arr_rvalid), .arr_rdata(arr_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [ROW_W-1:0] act,
                       input logic [ROW_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- array model ----------------
    logic [ROW_W-1:0] mem [NA];
    logic [ROW_W-1:0] ref_mem [NA];
    logic [3:0]       rdy_cnt;
    logic             pl_en = 0;
    logic [ADDR_W-1:0] pl_addr = '0;
    logic [ROW_W-1:0] pl_val = '0;
    int               wr_seen;
    bit               op_read_done;
    bit               order_err;

    assign arr_ready = (rdy_cnt[1:0] != 2'b11);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NA; a++) mem[a] <= '0;
            rdy_cnt      <= '0;
            arr_rvalid   <= 1'b0;
            arr_rdata    <= '0;
            wr_seen      <= 0;
            op_read_done <= 1'b0;
            order_err    <= 1'b0;
        end else begin
            rdy_cnt    <= rdy_cnt + 4'd1;
            arr_rvalid <= 1'b0;
            if (pl_en) mem[pl_addr] <= pl_val;
            if (arr_valid && arr_ready) begin
                if (!arr_we) begin
                    arr_rvalid   <= 1'b1;
                    arr_rdata    <= mem[arr_addr];
                    op_read_done <= 1'b1;
                    wr_seen      <= 0;
                    order_err    <= 1'b0;
                end else begin
                    mem[arr_addr][int'(arr_slice)*SW +: SW] <=
                        (mem[arr_addr][int'(arr_slice)*SW +: SW] & ~arr_wmask) |
                        (arr_wdata & arr_wmask);
                    wr_seen <= wr_seen + 1;
                    if (!op_read_done) order_err <= 1'b1;
                end
            end
            if (rsp_valid) op_read_done <= 1'b0;
        end
    end

    // ---------------- reference encoding ----------------
    task automatic enc_ref(input logic [ROW_W-1:0] old, input logic [LINE_W-1:0] nd,
                           output logic [ROW_W-1:0] st, output int cyc, output int fl);
        fl = 0;
        cyc = 0;
        for (int w = 0; w < NW; w++) begin
            logic [CW-1:0] o;
            logic [WORD_W-1:0] n;
            int cp, ci;
            o = old[w*CW +: CW];
            n = nd[w*WORD_W +: WORD_W];
            cp = $countones({1'b0, n} ^ o);
            ci = $countones({1'b1, ~n} ^ o);
            if (ci < cp) begin st[w*CW +: CW] = {1'b1, ~n}; fl += ci; end
            else         begin st[w*CW +: CW] = {1'b0, n};  fl += cp; end
        end
        for (int s = 0; s < NS; s++)
            if (st[s*SW +: SW] != old[s*SW +: SW]) cyc++;
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        bit                is_wr;
        logic [ADDR_W-1:0] addr;
        int                cyc;
        int                fl;
        logic [LINE_W-1:0] rdata;
        logic [ROW_W-1:0]  stored;
    } item_t;

    item_t sb_q [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 unexpected response", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (it.is_wr) begin
                    chk(rsp_wr_cycles == CYC_W'(it.cyc), "R6 cycles", ROW_W'(rsp_wr_cycles), ROW_W'(it.cyc));
                    chk(rsp_flips == FL_W'(it.fl), "R6 flips", ROW_W'(rsp_flips), ROW_W'(it.fl));
                    chk(wr_seen == it.cyc, "R5 slice writes seen", ROW_W'(wr_seen), ROW_W'(it.cyc));
                    chk(!order_err, "R2 write before read", ROW_W'(order_err), 0);
                    chk(mem[it.addr] == it.stored, "R3 R4 stored row", mem[it.addr], it.stored);
                end else begin
                    chk(rsp_rdata == it.rdata, "R7 read data", ROW_W'(rsp_rdata), ROW_W'(it.rdata));
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit we, input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] dat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a; req_wdata = dat;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 1'b0, "R8 busy after accept", ROW_W'(req_ready), 0);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] dat,
                         output int cyc, output int fl);
        item_t it;
        logic [ROW_W-1:0] st;
        enc_ref(ref_mem[a], dat, st, cyc, fl);
        ref_mem[a] = st;
        it.is_wr = 1; it.addr = a; it.cyc = cyc; it.fl = fl; it.rdata = '0; it.stored = st;
        sb_q.push_back(it);
        issue(1'b1, a, dat);
    endtask

    task automatic do_rd(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] exp);
        item_t it;
        it.is_wr = 0; it.addr = a; it.cyc = 0; it.fl = 0; it.rdata = exp; it.stored = '0;
        sb_q.push_back(it);
        issue(1'b0, a, '0);
    endtask

    task automatic preload(input logic [ADDR_W-1:0] a, input logic [ROW_W-1:0] v);
        @(negedge clk);
        pl_en = 1; pl_addr = a; pl_val = v;
        @(negedge clk);
        pl_en = 0;
        ref_mem[a] = v;
    endtask

    function automatic logic [LINE_W-1:0] rnd_line();
        logic [LINE_W-1:0] r;
        for (int w = 0; w < NW; w++) r[w*WORD_W +: WORD_W] = $urandom;
        return r;
    endfunction

    logic [LINE_W-1:0] logical [NA];

    initial begin
        int c, f;
        logic [LINE_W-1:0] ln;
        logic [ROW_W-1:0] pv;
        void'($urandom(17));
        for (int a = 0; a < NA; a++) begin ref_mem[a] = '0; logical[a] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", ROW_W'(req_ready), 1);
        chk(arr_valid == 1'b0, "R1 arr_valid", ROW_W'(arr_valid), 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", ROW_W'(rsp_valid), 0);

        // R10: zeros over zeros
        do_wr(0, '0, c, f);
        chk(c == 0 && f == 0, "R10 zero rewrite", ROW_W'(c + f), 0);

        // R3: all ones over zeros -> every word stored complemented
        do_wr(0, '1, c, f);
        chk(c == NS && f == NW, "R3 all-ones cost", ROW_W'(c * 1000 + f), ROW_W'(NS * 1000 + NW));
        chk(mem[0] == {NW{{1'b1, {WORD_W{1'b0}}}}}, "R3 all-ones image", mem[0], {NW{{1'b1, {WORD_W{1'b0}}}}});
        logical[0] = '1;
        do_rd(0, '1);

        // R5: change three bits in word 5 only -> one slice write
        ln = '1;
        ln[5*WORD_W +: 3] = 3'b000;
        do_wr(0, ln, c, f);
        chk(c == 1 && f == 3, "R5 single slice", ROW_W'(c * 1000 + f), ROW_W'(1003));
        logical[0] = ln;
        do_rd(0, ln);

        // R10: rewrite identical data
        do_wr(0, ln, c, f);
        chk(c == 0, "R10 identical rewrite", ROW_W'(c), 0);

        // R7: preload mixed marker bits and read back decoded
        for (int w = 0; w < NW; w++) pv[w*CW +: CW] = {w[0], 32'($urandom)};
        preload(1, pv);
        for (int w = 0; w < NW; w++)
            ln[w*WORD_W +: WORD_W] = pv[w*CW +: WORD_W] ^ {WORD_W{pv[w*CW + WORD_W]}};
        logical[1] = ln;
        do_rd(1, ln);

        // random mix across addresses
        for (int i = 0; i < 24; i++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom_range(0, NA - 1));
            if ($urandom_range(0, 2) != 0) begin
                ln = ($urandom_range(0, 1) == 1) ? (logical[a] ^ (rnd_line() & rnd_line() & rnd_line()))
                                                 : rnd_line();
                do_wr(a, ln, c, f);
                logical[a] = ln;
            end else begin
                do_rd(a, logical[a]);
            end
        end

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all responses seen", ROW_W'(sb_q.size()), 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule